// File: doc/BRIEF.md
# Load Queue Memory-Ordering Violation Detector

This block tracks in-flight loads in program order in a circular queue. Each entry holds a sequence number and, once the load executes, its effective address. When a load or a store executes, the block searches the younger loads that already have an address for one in the same 256-byte region. A match means a younger load read memory too early. The block keeps the oldest such load as the violator, so that the pipeline can squash back to it and refetch.

Loads enter at the tail. The slot index that the next load will take is always visible, so a store being inserted can record where its younger loads begin. Commit retires loads from the head by sequence number. A squash drops loads from the tail by sequence number and clears a held violator that the squash has made irrelevant. The whole search runs in parallel and takes one cycle.

Top module: `lq_order_chk`

## Requirements
- R1: After reset the queue is empty (count 0, tail index 0, full low), no violator is held, the fault pulse is low and the violation counter reads 0.
- R2: The queue holds DEPTH loads in DEPTH+1 slots. full_o is high exactly when the count equals DEPTH, and an allocation while full changes neither the count nor the tail index.
- R3: An allocation writes its sequence number into slot lq_tail_o and clears that slot's address-valid flag. The tail then advances by one. A store captures lq_tail_o at insertion as the first load index it must check.
- R4: When a load executes, its address is stored into its slot and the block searches the slots strictly after that slot, up to the tail. Slots with no address are skipped. A match means that bits [ADDR_W-1:8] are equal.
- R5: When a store executes, the search starts at the load index given with the store, including that slot, and runs up to the tail, using the same match rule.
- R6: Only the first match in program order counts. It is taken as the violator when none is held or when its sequence number is smaller than the held one. In that case fault_o pulses high for one cycle after the execution edge and the violation counter increases by one.
- R7: A first match that is not older than the held violator leaves the violator and the counter unchanged and gives no fault pulse.
- R8: A commit with value C retires, in one cycle, every load from the head whose sequence number is at most C.
- R9: A squash with value S removes, in one cycle, every load from the tail whose sequence number is greater than S. It also clears the held violator when S is smaller than the violator's sequence number.
- R10: Asserting viol_rd_i clears the held violator at that clock edge.
- R11: Head, tail and search indices wrap modulo DEPTH+1. A search that starts near the last slot continues into slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_i | input | 1 | Insert a load at the tail |
| alloc_seq_i | input | SEQ_W | Sequence number of the inserted load |
| lq_tail_o | output | PW | Slot the next load takes; captured by inserted stores |
| full_o | output | 1 | Queue holds DEPTH loads |
| count_o | output | PW | Number of live loads |
| ld_exec_i | input | 1 | A load executes |
| ld_idx_i | input | PW | Slot of the executing load |
| ld_addr_i | input | ADDR_W | Effective address of the executing load |
| st_exec_i | input | 1 | A store executes |
| st_lq_idx_i | input | PW | Load index recorded when the store was inserted |
| st_addr_i | input | ADDR_W | Effective address of the executing store |
| commit_i | input | 1 | Retire loads from the head |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_i | input | 1 | Remove loads from the tail |
| squash_seq_i | input | SEQ_W | Last surviving sequence number |
| viol_rd_i | input | 1 | Consume and clear the held violator |
| fault_o | output | 1 | One-cycle pulse when a new violator is taken |
| viol_valid_o | output | 1 | A violator is held |
| viol_seq_o | output | SEQ_W | Sequence number of the held violator |
| viol_idx_o | output | PW | Slot of the held violator when it was taken |
| viol_cnt_o | output | CNT_W | Count of violators taken |

## Verification
The assertions assume that at most one of allocate, load execute, store execute, commit, squash and read is strobed in any cycle. They also assume that sequence numbers are allocated in increasing order and that execute indices point at live slots. The commit and squash counts depend on the monotonic order in particular. The stimulus table issues one operation per vector, allocates strictly increasing sequence numbers and only executes slots it has allocated and not yet removed. It reaches the wrap-around cases by filling the queue, partially retiring it and allocating again.

// File: rtl/lq_order_pkg.sv
package lq_order_pkg;
  localparam int unsigned REGION_SHIFT = 8;
  typedef enum logic [1:0] {SCAN_NONE, SCAN_LOAD, SCAN_STORE} scan_kind_e;
endpackage

// File: rtl/lq_scan.sv
module lq_scan #(
  parameter int unsigned CAP    = 9,
  parameter int unsigned PW     = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SHIFT  = 8
) (
  input  logic [PW-1:0]                 start_i,
  input  logic [PW-1:0]                 tail_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CAP-1:0][ADDR_W-1:0]    ent_addr_i,
  input  logic [CAP-1:0]                ent_av_i,
  output logic                          hit_o,
  output logic [PW-1:0]                 hit_idx_o
);
  logic [PW:0] len;
  logic [PW:0] slot;

  always_comb begin
    if (tail_i >= start_i) len = {1'b0, tail_i} - {1'b0, start_i};
    else                   len = {1'b0, tail_i} + (PW+1)'(CAP) - {1'b0, start_i};
    hit_o     = 1'b0;
    hit_idx_o = '0;
    slot      = '0;
    // first match in program order wins
    for (int k = 0; k < CAP; k++) begin
      slot = {1'b0, start_i} + (PW+1)'(k);
      if (slot >= (PW+1)'(CAP)) slot = slot - (PW+1)'(CAP);
      if (!hit_o && ((PW+1)'(k) < len) && ent_av_i[slot[PW-1:0]] &&
          ent_addr_i[slot[PW-1:0]][ADDR_W-1:SHIFT] == addr_i[ADDR_W-1:SHIFT]) begin
        hit_o     = 1'b1;
        hit_idx_o = slot[PW-1:0];
      end
    end
  end
endmodule

// File: rtl/lq_viol_hold.sv
module lq_viol_hold #(
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned PW    = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cand_i,
  input  logic [SEQ_W-1:0] cand_seq_i,
  input  logic [PW-1:0]    cand_idx_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic             rd_i,
  output logic             fault_o,
  output logic             valid_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [PW-1:0]    idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             valid_q, fault_q;
  logic [SEQ_W-1:0] seq_q;
  logic [PW-1:0]    idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             v_eff, accept, clr_sq;

  always_comb begin
    v_eff  = valid_q & ~rd_i;
    accept = cand_i & (~v_eff | (cand_seq_i < seq_q));
    clr_sq = squash_i & valid_q & (squash_seq_i < seq_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      seq_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      fault_q <= accept;
      if (accept) begin
        valid_q <= 1'b1;
        seq_q   <= cand_seq_i;
        idx_q   <= cand_idx_i;
        cnt_q   <= cnt_q + CNT_W'(1);
      end else if (rd_i || clr_sq) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign fault_o = fault_q;
  assign valid_o = valid_q;
  assign seq_o   = seq_q;
  assign idx_o   = idx_q;
  assign cnt_o   = cnt_q;

  p_fault_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> valid_o);
  p_fault_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> cnt_o == $past(cnt_o) + CNT_W'(1));
  p_only_older_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && $past(valid_o && !rd_i) |-> seq_o < $past(seq_o));
  p_read_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !cand_i |=> !valid_o);
  p_squash_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i && !cand_i && valid_o && (squash_seq_i < seq_o) |=> !valid_o);
endmodule

// File: rtl/lq_order_chk.sv
module lq_order_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SEQ_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned CAP   = DEPTH + 1,
  localparam int unsigned PW    = $clog2(CAP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [SEQ_W-1:0]  alloc_seq_i,
  output logic [PW-1:0]     lq_tail_o,
  output logic              full_o,
  output logic [PW-1:0]     count_o,
  input  logic              ld_exec_i,
  input  logic [PW-1:0]     ld_idx_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              st_exec_i,
  input  logic [PW-1:0]     st_lq_idx_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              commit_i,
  input  logic [SEQ_W-1:0]  commit_seq_i,
  input  logic              squash_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  input  logic              viol_rd_i,
  output logic              fault_o,
  output logic              viol_valid_o,
  output logic [SEQ_W-1:0]  viol_seq_o,
  output logic [PW-1:0]     viol_idx_o,
  output logic [CNT_W-1:0]  viol_cnt_o
);
  import lq_order_pkg::*;

  logic [CAP-1:0][SEQ_W-1:0]  seq_q;
  logic [CAP-1:0][ADDR_W-1:0] addr_q;
  logic [CAP-1:0]             av_q;
  logic [PW-1:0]              head_q, tail_q, cnt_q;

  scan_kind_e      kind;
  logic [PW-1:0]   scan_start, hit_idx;
  logic [ADDR_W-1:0] scan_addr;
  logic            hit;
  logic [CAP-1:0]  live;
  logic [PW:0]     n_com, n_sq, head_nx, tail_nx, off;

  function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] v);
    return (v == PW'(CAP-1)) ? '0 : v + PW'(1);
  endfunction

  always_comb begin
    kind = ld_exec_i ? SCAN_LOAD : (st_exec_i ? SCAN_STORE : SCAN_NONE);
    scan_start = (kind == SCAN_LOAD) ? wrap_inc(ld_idx_i) : st_lq_idx_i;
    scan_addr  = (kind == SCAN_LOAD) ? ld_addr_i : st_addr_i;
    n_com = '0;
    n_sq  = '0;
    off   = '0;
    for (int i = 0; i < CAP; i++) begin
      if ((PW+1)'(i) >= {1'b0, head_q}) off = (PW+1)'(i) - {1'b0, head_q};
      else                              off = (PW+1)'(i) + (PW+1)'(CAP) - {1'b0, head_q};
      live[i] = off < {1'b0, cnt_q};
      if (live[i] && seq_q[i] <= commit_seq_i) n_com = n_com + 1'b1;
      if (live[i] && seq_q[i] >  squash_seq_i) n_sq  = n_sq + 1'b1;
    end
    head_nx = {1'b0, head_q} + n_com;
    if (head_nx >= (PW+1)'(CAP)) head_nx = head_nx - (PW+1)'(CAP);
    tail_nx = {1'b0, tail_q} + (PW+1)'(CAP) - n_sq;
    if (tail_nx >= (PW+1)'(CAP)) tail_nx = tail_nx - (PW+1)'(CAP);
  end

  lq_scan #(.CAP(CAP), .PW(PW), .ADDR_W(ADDR_W), .SHIFT(REGION_SHIFT)) u_scan (
    .start_i    (scan_start),
    .tail_i     (tail_q),
    .addr_i     (scan_addr),
    .ent_addr_i (addr_q),
    .ent_av_i   (av_q),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx)
  );

  lq_viol_hold #(.SEQ_W(SEQ_W), .PW(PW), .CNT_W(CNT_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cand_i       ((kind != SCAN_NONE) && hit),
    .cand_seq_i   (seq_q[hit_idx]),
    .cand_idx_i   (hit_idx),
    .squash_i     (squash_i),
    .squash_seq_i (squash_seq_i),
    .rd_i         (viol_rd_i),
    .fault_o      (fault_o),
    .valid_o      (viol_valid_o),
    .seq_o        (viol_seq_o),
    .idx_o        (viol_idx_o),
    .cnt_o        (viol_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= '0;
      addr_q <= '0;
      av_q   <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (squash_i) begin
      tail_q <= tail_nx[PW-1:0];
      cnt_q  <= cnt_q - n_sq[PW-1:0];
    end else if (commit_i) begin
      head_q <= head_nx[PW-1:0];
      cnt_q  <= cnt_q - n_com[PW-1:0];
    end else if (alloc_i && !full_o) begin
      seq_q[tail_q] <= alloc_seq_i;
      av_q[tail_q]  <= 1'b0;
      tail_q        <= wrap_inc(tail_q);
      cnt_q         <= cnt_q + PW'(1);
    end else if (ld_exec_i) begin
      addr_q[ld_idx_i] <= ld_addr_i;
      av_q[ld_idx_i]   <= 1'b1;
    end
  end

  assign lq_tail_o = tail_q;
  assign count_o   = cnt_q;
  assign full_o    = (cnt_q == PW'(DEPTH));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PW'(DEPTH));
  p_full_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && full_o && !squash_i && !commit_i |=> $stable(count_o) && $stable(lq_tail_o));
  p_commit_shrinks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !squash_i |=> count_o <= $past(count_o));
  p_squash_shrinks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> count_o <= $past(count_o));
  p_one_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({alloc_i, ld_exec_i, st_exec_i, commit_i, squash_i, viol_rd_i}));
endmodule

// File: tb/tb_lq_order_chk.sv
`timescale 1ns/100ps
module tb_lq_order_chk;
  localparam int unsigned PW = 4;
  localparam logic [2:0] OP_AL = 3'd1, OP_LX = 3'd2, OP_SX = 3'd3,
                         OP_CM = 3'd4, OP_SQ = 3'd5, OP_RD = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] a;
    logic [31:0] b;
    logic [3:0]  cnt;
    logic [3:0]  tail;
    logic        full;
    logic        vv;
    logic [15:0] vseq;
    logic [7:0]  vc;
    logic        f;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{OP_AL, 16'd10, 32'h0,    4'd1, 4'd1, 1'b0, 1'b0, 16'd0,  8'd0, 1'b0},
    '{OP_AL, 16'd11, 32'h0,    4'd2, 4'd2, 1'b0, 1'b0, 16'd0,  8'd0, 1'b0},
    '{OP_AL, 16'd12, 32'h0,    4'd3, 4'd3, 1'b0, 1'b0, 16'd0,  8'd0, 1'b0},
    '{OP_AL, 16'd13, 32'h0,    4'd4, 4'd4, 1'b0, 1'b0, 16'd0,  8'd0, 1'b0},
    '{OP_LX, 16'd2,  32'h1234, 4'd4, 4'd4, 1'b0, 1'b0, 16'd0,  8'd0, 1'b0},
    '{OP_LX, 16'd3,  32'h1299, 4'd4, 4'd4, 1'b0, 1'b0, 16'd0,  8'd0, 1'b0},
    '{OP_LX, 16'd1,  32'h12F0, 4'd4, 4'd4, 1'b0, 1'b1, 16'd12, 8'd1, 1'b1},
    '{OP_LX, 16'd0,  32'h1200, 4'd4, 4'd4, 1'b0, 1'b1, 16'd11, 8'd2, 1'b1},
    '{OP_SX, 16'd0,  32'h12AB, 4'd4, 4'd4, 1'b0, 1'b1, 16'd10, 8'd3, 1'b1},
    '{OP_SX, 16'd1,  32'h1280, 4'd4, 4'd4, 1'b0, 1'b1, 16'd10, 8'd3, 1'b0},
    '{OP_SX, 16'd0,  32'h5500, 4'd4, 4'd4, 1'b0, 1'b1, 16'd10, 8'd3, 1'b0},
    '{OP_RD, 16'd0,  32'h0,    4'd4, 4'd4, 1'b0, 1'b0, 16'd0,  8'd3, 1'b0},
    '{OP_SX, 16'd2,  32'h1200, 4'd4, 4'd4, 1'b0, 1'b1, 16'd12, 8'd4, 1'b1},
    '{OP_SQ, 16'd11, 32'h0,    4'd2, 4'd2, 1'b0, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_CM, 16'd10, 32'h0,    4'd1, 4'd2, 1'b0, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_CM, 16'd5,  32'h0,    4'd1, 4'd2, 1'b0, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_AL, 16'd20, 32'h0,    4'd2, 4'd3, 1'b0, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_AL, 16'd21, 32'h0,    4'd3, 4'd4, 1'b0, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_AL, 16'd22, 32'h0,    4'd4, 4'd5, 1'b0, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_AL, 16'd23, 32'h0,    4'd5, 4'd6, 1'b0, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_AL, 16'd24, 32'h0,    4'd6, 4'd7, 1'b0, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_AL, 16'd25, 32'h0,    4'd7, 4'd8, 1'b0, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_AL, 16'd26, 32'h0,    4'd8, 4'd0, 1'b1, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_AL, 16'd99, 32'h0,    4'd8, 4'd0, 1'b1, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_LX, 16'd8,  32'h7700, 4'd8, 4'd0, 1'b1, 1'b0, 16'd0,  8'd4, 1'b0},
    '{OP_SX, 16'd1,  32'h7711, 4'd8, 4'd0, 1'b1, 1'b1, 16'd26, 8'd5, 1'b1},
    '{OP_CM, 16'd21, 32'h0,    4'd5, 4'd0, 1'b0, 1'b1, 16'd26, 8'd5, 1'b0},
    '{OP_AL, 16'd27, 32'h0,    4'd6, 4'd1, 1'b0, 1'b1, 16'd26, 8'd5, 1'b0},
    '{OP_LX, 16'd7,  32'h7705, 4'd6, 4'd1, 1'b0, 1'b1, 16'd26, 8'd5, 1'b0},
    '{OP_RD, 16'd0,  32'h0,    4'd6, 4'd1, 1'b0, 1'b0, 16'd0,  8'd5, 1'b0},
    '{OP_LX, 16'd8,  32'h3300, 4'd6, 4'd1, 1'b0, 1'b0, 16'd0,  8'd5, 1'b0},
    '{OP_LX, 16'd0,  32'h3301, 4'd6, 4'd1, 1'b0, 1'b0, 16'd0,  8'd5, 1'b0},
    '{OP_LX, 16'd8,  32'h3300, 4'd6, 4'd1, 1'b0, 1'b1, 16'd27, 8'd6, 1'b1},
    '{OP_SQ, 16'd25, 32'h0,    4'd4, 4'd8, 1'b0, 1'b0, 16'd0,  8'd6, 1'b0},
    '{OP_CM, 16'd100,32'h0,    4'd0, 4'd8, 1'b0, 1'b0, 16'd0,  8'd6, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc = 0, ld_exec = 0, st_exec = 0, commit = 0, squash = 0, vrd = 0;
  logic [15:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [PW-1:0] ld_idx = '0, st_idx = '0;
  logic [31:0] ld_addr = '0, st_addr = '0;
  logic [PW-1:0] tail, cnt, vidx;
  logic full, fault, vv;
  logic [15:0] vseq;
  logic [7:0] vcnt;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lq_order_chk dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_i(alloc), .alloc_seq_i(alloc_seq), .lq_tail_o(tail), .full_o(full), .count_o(cnt),
    .ld_exec_i(ld_exec), .ld_idx_i(ld_idx), .ld_addr_i(ld_addr),
    .st_exec_i(st_exec), .st_lq_idx_i(st_idx), .st_addr_i(st_addr),
    .commit_i(commit), .commit_seq_i(commit_seq), .squash_i(squash), .squash_seq_i(squash_seq),
    .viol_rd_i(vrd), .fault_o(fault), .viol_valid_o(vv), .viol_seq_o(vseq),
    .viol_idx_o(vidx), .viol_cnt_o(vcnt)
  );

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic string tag(int i, int kind, vec_t v);
    if (kind == 1) return (i >= 22) ? "R11" : "R3";
    if (kind == 3) return "R6";
    if (kind == 0) begin
      case (v.op)
        OP_AL: return "R2";
        OP_CM: return "R8";
        OP_SQ: return "R9";
        default: return "R3";
      endcase
    end
    case (v.op)
      OP_LX: return v.f ? "R6" : (v.vv ? "R7" : "R4");
      OP_SX: return v.f ? "R6" : (v.vv ? "R7" : "R5");
      OP_RD: return "R10";
      OP_SQ: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(vec_t v);
    alloc = (v.op == OP_AL); ld_exec = (v.op == OP_LX); st_exec = (v.op == OP_SX);
    commit = (v.op == OP_CM); squash = (v.op == OP_SQ); vrd = (v.op == OP_RD);
    alloc_seq = v.a; commit_seq = v.a; squash_seq = v.a;
    ld_idx = v.a[PW-1:0]; st_idx = v.a[PW-1:0];
    ld_addr = v.b; st_addr = v.b;
  endtask

  task automatic idle();
    alloc = 0; ld_exec = 0; st_exec = 0; commit = 0; squash = 0; vrd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "count", int'(cnt), 0);
    chk("R1", "tail", int'(tail), 0);
    chk("R1", "full", int'(full), 0);
    chk("R1", "viol_valid", int'(vv), 0);
    chk("R1", "viol_cnt", int'(vcnt), 0);
    chk("R1", "fault", int'(fault), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      idle();
      chk(tag(i, 0, VEC[i]), $sformatf("v%0d count", i), int'(cnt), int'(VEC[i].cnt));
      chk(tag(i, 0, VEC[i]), $sformatf("v%0d full", i), int'(full), int'(VEC[i].full));
      chk(tag(i, 1, VEC[i]), $sformatf("v%0d tail", i), int'(tail), int'(VEC[i].tail));
      chk(tag(i, 2, VEC[i]), $sformatf("v%0d viol_valid", i), int'(vv), int'(VEC[i].vv));
      if (VEC[i].vv)
        chk(tag(i, 2, VEC[i]), $sformatf("v%0d viol_seq", i), int'(vseq), int'(VEC[i].vseq));
      chk(tag(i, 2, VEC[i]), $sformatf("v%0d fault", i), int'(fault), int'(VEC[i].f));
      chk(tag(i, 3, VEC[i]), $sformatf("v%0d viol_cnt", i), int'(vcnt), int'(VEC[i].vc));
    end
    // fault is a single-cycle pulse (R6)
    drive(VEC[6]);
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R6", "fault pulse width", int'(fault), 0);
    // reset mid-run returns to the R1 state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "count after reset", int'(cnt), 0);
    chk("R1", "viol_cnt after reset", int'(vcnt), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule